// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block arbitrates the interrupt sources of a byte-wide serial port controller. Five single-cycle request pulses come in from the rest of the port: receive line error, receive data ready, receive character timeout, transmit holding register empty and modem status change. Each pulse sets a pending flag. The flag stays set even while its source is masked. The pending flags are gated by a four-bit enable register. A fixed priority picks the most urgent gated source and stores its identification code. A single registered interrupt line is driven whenever a source is reported.

Software reaches the unit through a small byte bus. It can write and read the enable register and read the identification register. The unit also decodes accesses to registers held elsewhere in the port, and each such access clears the matching source: the data register (a read pops received data, a write loads the transmitter), the line status register and the modem status register. Whenever the reported source is cleared, the next most urgent enabled pending source takes its place.

Top module: `uart_irq_ident`

## Requirements
- R1: The identification code is one of the following, listed from most to least urgent: line error 0x6, receive data 0x4, character timeout 0xC, transmit empty 0x2, modem status 0x0. The code 0x1 means that nothing is reported. The code always names the most urgent source that is both pending and enabled.
- R2: The enable register is at address 1. Bit 0 gates both receive data and character timeout, bit 1 gates transmit empty, bit 2 gates line error and bit 3 gates modem status. Only bits 3:0 are stored, so a read of address 1 returns bits 7:4 as zero. A read of any address other than 1 or 2 returns 0x00.
- R3: A request pulse sets its pending flag whether or not its source is enabled. A write to the enable register re-evaluates the reported code in the same cycle that the new enable value is stored.
- R4: A read of the identification register (address 2) returns bits 7:6 = 11, bits 5:4 = 00 and the code in bits 3:0. The idle value is therefore 0xC1.
- R5: A read of address 2 clears the transmit-empty flag only if 0x2 is the code being reported at that moment. A write to address 0 always clears the transmit-empty flag.
- R6: A read of address 5 clears the line-error flag. A read of address 0 clears both the receive-data flag and the character-timeout flag. A read of address 6 clears the modem-status flag.
- R7: After a clear, the next most urgent enabled pending source is reported. If no such source remains, the code returns to 0x1 and the interrupt line falls.
- R8: After a synchronous reset, the identification register reads 0xC1, the enable register reads 0x00 and the interrupt line is low.
- R9: The interrupt line and the read data are registered. A request, clear or enable write sampled at one clock edge affects the code and the interrupt line right after that edge. The data for a read sampled at an edge is valid right after that same edge. The interrupt line is high exactly when code bit 0 is 0.
- R10: When a source receives a request and a clear in the same cycle, the request wins and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_line_err | input | 1 | Receive line error request pulse |
| req_rx_data | input | 1 | Receive data ready request pulse |
| req_rx_timeout | input | 1 | Character timeout request pulse |
| req_tx_empty | input | 1 | Transmit holding register empty request pulse |
| req_modem | input | 1 | Modem status change request pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Registered interrupt line |

## Verification
The bench builds the unit with its default address map: data at 0, enable at 1, identification at 2, line status at 5 and modem status at 6, with a three-bit address. The bench drives every side-effect strobe through this map. Random address traffic also reaches the unused addresses 3, 4 and 7, so the bench can confirm that those accesses neither clear a flag nor return data. Directed sequences walk all five sources down the priority chain, and a random phase mixes requests, clears and enable writes in the same cycle.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_SRC = 5;
  localparam int SRC_LINE = 0;
  localparam int SRC_RXD  = 1;
  localparam int SRC_TMO  = 2;
  localparam int SRC_TXE  = 3;
  localparam int SRC_MDM  = 4;

  localparam logic [3:0] CODE_NONE = 4'h1;
  localparam logic [3:0] CODE_LINE = 4'h6;
  localparam logic [3:0] CODE_RXD  = 4'h4;
  localparam logic [3:0] CODE_TMO  = 4'hC;
  localparam logic [3:0] CODE_TXE  = 4'h2;
  localparam logic [3:0] CODE_MDM  = 4'h0;

  function automatic logic [3:0] code_of(input int idx);
    case (idx)
      SRC_LINE: code_of = CODE_LINE;
      SRC_RXD:  code_of = CODE_RXD;
      SRC_TMO:  code_of = CODE_TMO;
      SRC_TXE:  code_of = CODE_TXE;
      SRC_MDM:  code_of = CODE_MDM;
      default:  code_of = CODE_NONE;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_pending.sv
module uart_irq_pending #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] pend_next_o
);
  logic [N-1:0] pend_q;

  for (genvar g = 0; g < N; g++) begin : g_flag
    assign pend_next_o[g] = set_i[g] | (pend_q[g] & ~clr_i[g]);

    always_ff @(posedge clk) begin
      if (rst) pend_q[g] <= 1'b0;
      else     pend_q[g] <= pend_next_o[g];
    end

    // R3 / R10: a request always leaves the flag set, even with a clear
    assert_req_sets_R10: assert property (@(posedge clk) disable iff (rst)
      set_i[g] |=> pend_q[g]);
    // R6: a lone clear drops the flag
    assert_clear_drops_R6: assert property (@(posedge clk) disable iff (rst)
      (clr_i[g] && !set_i[g]) |=> !pend_q[g]);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] gate_i,
  output logic [3:0]   code_o
);
  // index 0 is most urgent: scanning downward lets the lowest index win
  always_comb begin
    code_o = CODE_NONE;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i] && gate_i[i]) code_o = code_of(i);
    end
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int A_DATA = 0,
  parameter int A_ENA  = 1,
  parameter int A_IID  = 2,
  parameter int A_LSR  = 5,
  parameter int A_MSR  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_line_err,
  input  logic              req_rx_data,
  input  logic              req_rx_timeout,
  input  logic              req_tx_empty,
  input  logic              req_modem,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq
);
  localparam logic [7:0] ENA_MASK = 8'h0F;

  logic [7:0]         en_q, en_next;
  logic [3:0]         iid_q, code_next;
  logic               irq_q;
  logic [7:0]         rdata_q;
  logic [NUM_SRC-1:0] set_v, clr_v, pend_q, pend_next, gate_next, gate_q;

  wire hit_data = (bus_addr == ADDR_W'(A_DATA));
  wire hit_ena  = (bus_addr == ADDR_W'(A_ENA));
  wire hit_iid  = (bus_addr == ADDR_W'(A_IID));
  wire hit_lsr  = (bus_addr == ADDR_W'(A_LSR));
  wire hit_msr  = (bus_addr == ADDR_W'(A_MSR));

  assign en_next = (bus_wr && hit_ena) ? (bus_wdata & ENA_MASK) : en_q;

  function automatic logic [NUM_SRC-1:0] gates(input logic [7:0] e);
    logic [NUM_SRC-1:0] v;
    v[SRC_LINE] = e[2];
    v[SRC_RXD]  = e[0];
    v[SRC_TMO]  = e[0];
    v[SRC_TXE]  = e[1];
    v[SRC_MDM]  = e[3];
    return v;
  endfunction

  assign gate_next = gates(en_next);
  assign gate_q    = gates(en_q);

  assign set_v[SRC_LINE] = req_line_err;
  assign set_v[SRC_RXD]  = req_rx_data;
  assign set_v[SRC_TMO]  = req_rx_timeout;
  assign set_v[SRC_TXE]  = req_tx_empty;
  assign set_v[SRC_MDM]  = req_modem;

  assign clr_v[SRC_LINE] = bus_rd && hit_lsr;
  assign clr_v[SRC_RXD]  = bus_rd && hit_data;
  assign clr_v[SRC_TMO]  = bus_rd && hit_data;
  assign clr_v[SRC_TXE]  = (bus_wr && hit_data) || (bus_rd && hit_iid && iid_q == CODE_TXE);
  assign clr_v[SRC_MDM]  = bus_rd && hit_msr;

  uart_irq_pending #(.N(NUM_SRC)) u_pend (
    .clk(clk), .rst(rst), .set_i(set_v), .clr_i(clr_v),
    .pend_o(pend_q), .pend_next_o(pend_next)
  );

  uart_irq_prio #(.N(NUM_SRC)) u_prio (
    .pend_i(pend_next), .gate_i(gate_next), .code_o(code_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 8'h00;
      iid_q   <= CODE_NONE;
      irq_q   <= 1'b0;
      rdata_q <= 8'h00;
    end else begin
      en_q  <= en_next;
      iid_q <= code_next;
      irq_q <= ~code_next[0];
      if (bus_rd && hit_ena)      rdata_q <= en_q;
      else if (bus_rd && hit_iid) rdata_q <= {4'b1100, iid_q};
      else                        rdata_q <= 8'h00;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;

  // R1: an enabled line error always takes the top slot
  assert_line_first_R1: assert property (@(posedge clk) disable iff (rst)
    (pend_q[SRC_LINE] && en_q[2]) |-> (iid_q == CODE_LINE));
  // R7: nothing gated and pending means the idle code
  assert_idle_code_R7: assert property (@(posedge clk) disable iff (rst)
    ((pend_q & gate_q) == '0) |-> (iid_q == CODE_NONE));
  // R2: only the low nibble of an enable write is kept
  assert_ena_store_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && hit_ena) |=> (en_q == ($past(bus_wdata) & ENA_MASK)));
  // R4: identification reads carry the fixed upper pattern
  assert_iid_format_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && hit_iid) |=> (bus_rdata[7:4] == 4'b1100));
  // R9: interrupt line tracks the code's idle bit
  assert_irq_line_R9: assert property (@(posedge clk) disable iff (rst)
    irq == !iid_q[0]);
endmodule

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_line_err = 0, req_rx_data = 0, req_rx_timeout = 0, req_tx_empty = 0, req_modem = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic irq;

  always #4 clk = ~clk;

  uart_irq_ident uut (
    .clk(clk), .rst(rst),
    .req_line_err(req_line_err), .req_rx_data(req_rx_data),
    .req_rx_timeout(req_rx_timeout), .req_tx_empty(req_tx_empty),
    .req_modem(req_modem), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  string tag = "R8";

  // behavioural reference: flags indexed line, rxd, timeout, txe, modem
  bit [4:0] m_pend;
  bit [3:0] m_en;
  bit [3:0] m_iid;
  bit       m_irq;
  bit [7:0] m_rdata;
  bit       m_live = 0;

  function automatic bit [3:0] m_pick(bit [4:0] p, bit [3:0] e);
    if (p[0] && e[2]) return 4'h6;
    if (p[1] && e[0]) return 4'h4;
    if (p[2] && e[0]) return 4'hC;
    if (p[3] && e[1]) return 4'h2;
    if (p[4] && e[3]) return 4'h0;
    return 4'h1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pend = 0; m_en = 0; m_iid = 4'h1; m_irq = 0; m_rdata = 0; m_live = 1;
    end else begin
      bit [4:0] clr;
      bit [4:0] req;
      bit [3:0] en_n;
      req = {req_modem, req_tx_empty, req_rx_timeout, req_rx_data, req_line_err};
      clr = 0;
      if (bus_rd && bus_addr == 5) clr[0] = 1;
      if (bus_rd && bus_addr == 0) begin clr[1] = 1; clr[2] = 1; end
      if (bus_wr && bus_addr == 0) clr[3] = 1;
      if (bus_rd && bus_addr == 2 && m_iid == 4'h2) clr[3] = 1;
      if (bus_rd && bus_addr == 6) clr[4] = 1;
      if (bus_rd && bus_addr == 1)      m_rdata = {4'h0, m_en};
      else if (bus_rd && bus_addr == 2) m_rdata = {4'hC, m_iid};
      else                              m_rdata = 8'h00;
      en_n = (bus_wr && bus_addr == 1) ? bus_wdata[3:0] : m_en;
      m_pend = (m_pend & ~clr) | req;
      m_en = en_n;
      m_iid = m_pick(m_pend, m_en);
      m_irq = !m_iid[0];
    end
  end

  // continuous comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (m_live && !rst) begin
      checks++;
      if (irq !== m_irq || bus_rdata !== m_rdata) begin
        errors++;
        $display("FAIL %s model: irq %0b rdata %02h expected irq %0b rdata %02h",
                 tag, irq, bus_rdata, m_irq, m_rdata);
      end
    end
  end

  task automatic idle();
    bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    {req_modem, req_tx_empty, req_rx_timeout, req_rx_data, req_line_err} = 0;
  endtask

  task automatic op(input bit rd, input bit wr, input bit [2:0] a, input bit [7:0] d, input bit [4:0] rq);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
    {req_modem, req_tx_empty, req_rx_timeout, req_rx_data, req_line_err} = rq;
    @(negedge clk);
    idle();
  endtask

  task automatic expect_rd(input bit [2:0] a, input bit [7:0] exp, input string t);
    op(1, 0, a, 0, 0);
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s read addr %0d got %02h expected %02h", t, a, bus_rdata, exp);
    end
  endtask

  task automatic expect_irq(input bit exp, input string t);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq got %0b expected %0b", t, irq, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R8 reset state
    tag = "R8";
    expect_irq(0, "R8");
    expect_rd(2, 8'hC1, "R8");
    expect_rd(1, 8'h00, "R8");
    // R3 disabled request is kept pending
    tag = "R3";
    op(0, 0, 0, 0, 5'b00001);
    expect_irq(0, "R3");
    expect_rd(2, 8'hC1, "R3");
    op(0, 1, 1, 8'hFF, 0);
    expect_irq(1, "R3");
    expect_rd(1, 8'h0F, "R2");
    expect_rd(2, 8'hC6, "R1");
    // R1/R6/R7 walk down the priority chain
    tag = "R1";
    op(0, 0, 0, 0, 5'b11110);
    expect_rd(2, 8'hC6, "R1");
    op(1, 0, 5, 0, 0);
    expect_rd(2, 8'hC4, "R6");
    op(1, 0, 0, 0, 0);
    expect_rd(2, 8'hC2, "R7");
    expect_rd(2, 8'hC0, "R5");
    op(1, 0, 6, 0, 0);
    expect_irq(0, "R7");
    expect_rd(2, 8'hC1, "R7");
    // R1 timeout alone, R9 same-edge response
    op(0, 0, 0, 0, 5'b00100);
    expect_irq(1, "R9");
    expect_rd(2, 8'hCC, "R1");
    op(1, 0, 0, 0, 0);
    expect_rd(2, 8'hC1, "R6");
    // R5 identification read does not clear a non-reported transmit source
    tag = "R5";
    op(0, 0, 0, 0, 5'b01010);
    expect_rd(2, 8'hC4, "R5");
    op(1, 0, 0, 0, 0);
    expect_rd(2, 8'hC2, "R5");
    op(0, 1, 0, 8'h55, 0);
    expect_rd(2, 8'hC1, "R5");
    // R2 gating of transmit empty
    tag = "R2";
    op(0, 0, 0, 0, 5'b01000);
    op(0, 1, 1, 8'h0D, 0);
    expect_irq(0, "R2");
    expect_rd(2, 8'hC1, "R2");
    op(0, 1, 1, 8'h0F, 0);
    expect_irq(1, "R3");
    expect_rd(2, 8'hC2, "R3");
    op(0, 1, 0, 8'h00, 0);
    // R10 request beats clear in the same cycle
    tag = "R10";
    op(0, 0, 0, 0, 5'b00001);
    op(1, 0, 5, 0, 5'b00001);
    expect_rd(2, 8'hC6, "R10");
    op(1, 0, 5, 0, 0);
    expect_rd(2, 8'hC1, "R10");
    expect_rd(3, 8'h00, "R2");
    // mixed random traffic against the model
    tag = "R7";
    for (int i = 0; i < 4000; i++) begin
      bit [4:0] rq;
      rq = 0;
      for (int k = 0; k < 5; k++) if ($urandom_range(0, 9) == 0) rq[k] = 1;
      bus_rd = ($urandom_range(0, 2) == 0);
      bus_wr = ($urandom_range(0, 7) == 0);
      bus_addr = 3'($urandom_range(0, 7));
      bus_wdata = 8'($urandom);
      {req_modem, req_tx_empty, req_rx_timeout, req_rx_data, req_line_err} = rq;
      @(negedge clk);
    end
    idle();
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule